// File: doc/BRIEF.md
# Wait-for-Interrupt Sleep Controller

This block manages the single low-power sleep state of a small processor core. When the decoder reports a wait-for-interrupt instruction, the controller makes one of three choices. It can treat the instruction as a no-operation (in debug mode or while single-stepping). It can reject the instruction with an illegal-instruction pulse (user privilege with the timeout-wait control bit set). Otherwise it puts the execute side to sleep. While the core sleeps, the controller holds the counters through a counter-inhibit output. Interrupt requests keep collecting in the pending vector outside this block.

The block also holds a reduced instruction fetch sequencer with four states: restart, request, pending and parked. The sequencer moves to its parked state once the execute side sleeps and the prefetch buffer cannot take another word. The external sleep status output rises only when the execute side is asleep and the sequencer is parked at the same time. The core wakes as soon as any interrupt is both pending and enabled, or when a debug halt is requested. Sleep entry waits for any open fetch to receive its response, so no bus transfer is left hanging.

Top module: `wfi_sleep_ctrl`

## Requirements
- R1: A wait-for-interrupt strobe sets sleepReq and cntInhibit on the next rising edge when dbgMode and singleStep are low, the pair (privUser=1, timeoutWait=1) does not hold, no fetch is outstanding and no wake condition is present.
- R2: A strobe with privUser=1 and timeoutWait=1, and with dbgMode and singleStep low, makes illegalExc high for exactly the one cycle after that edge. The core does not sleep.
- R3: A strobe while dbgMode or singleStep is high is a no-operation: no illegalExc, no sleep. This takes priority over R2.
- R4: While asleep, sleepReq and cntInhibit fall on the first rising edge at which any bit of irqPend AND irqEn is 1. With no overlap they stay high.
- R5: While asleep, dbgHaltReq high wakes the core on the next rising edge.
- R6: A strobe that arrives while the wake condition already holds completes without sleeping, and it is not remembered afterwards.
- R7: In the request state, fetchReq equals bufFree combinationally. An issued fetch holds the sequencer in pending, with fetchReq low, until fetchAck or fetchErr.
- R8: With the execute side asleep and bufFree low, the sequencer parks on the next edge after it reaches the request state, and sleepOut then goes high.
- R9: A parked sequencer returns to the request state on the edge after the execute side wakes, so fetchReq can follow bufFree again one cycle after the wake.
- R10: sleepOut is never high while a fetch is outstanding, and it falls in the same cycle as sleepReq.
- R11: A strobe accepted while a fetch is outstanding delays sleep entry until the edge on which fetchAck or fetchErr is seen.
- R12: While rstN is low, sleepReq, cntInhibit, sleepOut, illegalExc and fetchReq are 0, and the sequencer is in restart. It reaches request one edge after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low reset |
| wfiExec | input | 1 | One-cycle strobe: wait-for-interrupt decoded |
| privUser | input | 1 | 1 = core runs at user privilege |
| timeoutWait | input | 1 | Timeout-wait control bit |
| dbgMode | input | 1 | Core is in debug mode |
| singleStep | input | 1 | Single-step execution active |
| irqPend | input | NIRQ | Interrupt pending vector |
| irqEn | input | NIRQ | Interrupt enable vector |
| dbgHaltReq | input | 1 | Debug session request |
| bufFree | input | 1 | Prefetch buffer can accept a word |
| fetchAck | input | 1 | Fetch response: acknowledge |
| fetchErr | input | 1 | Fetch response: error |
| fetchReq | output | 1 | Fetch request strobe |
| sleepReq | output | 1 | Execute side is asleep |
| cntInhibit | output | 1 | Hold counter increments |
| illegalExc | output | 1 | Illegal-instruction exception pulse |
| sleepOut | output | 1 | Core fully asleep and fetch parked |

## Verification
sleepReq, cntInhibit and illegalExc are registered, so they are due one edge after the strobe or the wake condition. sleepOut needs a second edge for the sequencer to park, but it falls on the same edge as the wake. fetchReq is combinational and is sampled shortly after its inputs change. The bench drives on the falling edge and reads each result at the falling edge that follows the rising edge at which the result is due. It sweeps every combination of the four mode inputs and every pair of 4-bit pending and enable vectors.

// File: rtl/sleep_pkg.sv
package sleep_pkg;
  typedef enum logic [1:0] {
    FS_RESTART = 2'd0,
    FS_REQUEST = 2'd1,
    FS_PENDING = 2'd2,
    FS_PARKED  = 2'd3
  } fetchState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic sleep;
    logic wake;
  } execStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic open;
    logic parked;
  } fetchStatus_t;
endpackage

// File: rtl/sleep_ctrl.sv
module sleep_ctrl
  import sleep_pkg::*;
#(
  parameter int NIRQ = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         wfiExec,
  input  logic         privUser,
  input  logic         timeoutWait,
  input  logic         dbgMode,
  input  logic         singleStep,
  input  logic [NIRQ-1:0] irqPend,
  input  logic [NIRQ-1:0] irqEn,
  input  logic         dbgHaltReq,
  input  fetchStatus_t fetchSt,
  output execStrobe_t  strobe,
  output logic         illegalExc
);
  logic sleeping, armed;
  logic wakeCond, wfiNop, wfiTrap, wfiGo, want, enter;

  always_comb begin
    wakeCond = (|(irqPend & irqEn)) | dbgHaltReq;
    wfiNop   = dbgMode | singleStep;
    wfiTrap  = !wfiNop && privUser && timeoutWait;
    wfiGo    = wfiExec && !sleeping && !wfiNop && !wfiTrap;
    want     = wfiGo | armed;
    enter    = want && !wakeCond && !fetchSt.open;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sleeping   <= 1'b0;
      armed      <= 1'b0;
      illegalExc <= 1'b0;
    end else begin
      illegalExc <= wfiExec && !sleeping && wfiTrap;
      armed      <= want && !enter && !wakeCond;
      if (sleeping) begin
        if (wakeCond) sleeping <= 1'b0;
      end else if (enter) begin
        sleeping <= 1'b1;
      end
    end
  end

  assign strobe.sleep = sleeping;
  assign strobe.wake  = sleeping && wakeCond;
endmodule

// File: rtl/fetch_seq.sv
module fetch_seq
  import sleep_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  execStrobe_t  strobe,
  input  logic         bufFree,
  input  logic         fetchAck,
  input  logic         fetchErr,
  output logic         fetchReq,
  output fetchStatus_t fetchSt,
  output fetchState_e  stateOut
);
  fetchState_e state;
  logic resp;

  assign resp = fetchAck | fetchErr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= FS_RESTART;
    end else begin
      case (state)
        FS_RESTART: state <= FS_REQUEST;
        FS_REQUEST: begin
          if (bufFree)           state <= FS_PENDING;
          else if (strobe.sleep) state <= FS_PARKED;
        end
        FS_PENDING: if (resp)          state <= FS_REQUEST;
        FS_PARKED:  if (!strobe.sleep) state <= FS_REQUEST;
        default:    state <= FS_RESTART;
      endcase
    end
  end

  assign fetchReq       = (state == FS_REQUEST) && bufFree;
  assign fetchSt.open   = (state == FS_PENDING) && !resp;
  assign fetchSt.parked = (state == FS_PARKED);
  assign stateOut       = state;
endmodule

// File: rtl/wfi_sleep_ctrl.sv
module wfi_sleep_ctrl
  import sleep_pkg::*;
#(
  parameter int NIRQ = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            wfiExec,
  input  logic            privUser,
  input  logic            timeoutWait,
  input  logic            dbgMode,
  input  logic            singleStep,
  input  logic [NIRQ-1:0] irqPend,
  input  logic [NIRQ-1:0] irqEn,
  input  logic            dbgHaltReq,
  input  logic            bufFree,
  input  logic            fetchAck,
  input  logic            fetchErr,
  output logic            fetchReq,
  output logic            sleepReq,
  output logic            cntInhibit,
  output logic            illegalExc,
  output logic            sleepOut
);
  execStrobe_t  strobe;
  fetchStatus_t fetchSt;
  fetchState_e  fetchState;

  sleep_ctrl #(.NIRQ(NIRQ)) uCtrl (
    .clk(clk), .rstN(rstN), .wfiExec(wfiExec), .privUser(privUser),
    .timeoutWait(timeoutWait), .dbgMode(dbgMode), .singleStep(singleStep),
    .irqPend(irqPend), .irqEn(irqEn), .dbgHaltReq(dbgHaltReq),
    .fetchSt(fetchSt), .strobe(strobe), .illegalExc(illegalExc)
  );

  fetch_seq uFetch (
    .clk(clk), .rstN(rstN), .strobe(strobe), .bufFree(bufFree),
    .fetchAck(fetchAck), .fetchErr(fetchErr), .fetchReq(fetchReq),
    .fetchSt(fetchSt), .stateOut(fetchState)
  );

  assign sleepReq   = strobe.sleep;
  assign cntInhibit = strobe.sleep;
  assign sleepOut   = strobe.sleep && fetchSt.parked;
endmodule

// File: rtl/sleep_chk.sv
module sleep_chk
  import sleep_pkg::*;
#(
  parameter int NIRQ = 16
) (
  input logic            clk,
  input logic            rstN,
  input logic            wfiExec,
  input logic            privUser,
  input logic            timeoutWait,
  input logic            dbgMode,
  input logic            singleStep,
  input logic [NIRQ-1:0] irqPend,
  input logic [NIRQ-1:0] irqEn,
  input logic            dbgHaltReq,
  input logic            fetchAck,
  input logic            fetchErr,
  input logic            sleepReq,
  input logic            illegalExc,
  input logic            sleepOut,
  input fetchState_e     fetchState
);
  a_r2_illegal_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (wfiExec && !sleepReq && privUser && timeoutWait && !dbgMode && !singleStep)
      |=> (illegalExc && !sleepReq));

  a_r3_nop: assert property (@(posedge clk) disable iff (!rstN)
    (wfiExec && !sleepReq && (dbgMode || singleStep)) |=> (!illegalExc && !sleepReq));

  a_r4_irq_wake: assert property (@(posedge clk) disable iff (!rstN)
    (sleepReq && ((irqPend & irqEn) != '0)) |=> !sleepReq);

  a_r5_dbg_wake: assert property (@(posedge clk) disable iff (!rstN)
    (sleepReq && dbgHaltReq) |=> !sleepReq);

  a_r10_no_open_fetch: assert property (@(posedge clk) disable iff (!rstN)
    (fetchState == FS_PENDING) |-> !sleepOut);

  a_r11_entry_blocked: assert property (@(posedge clk) disable iff (!rstN)
    (!sleepReq && fetchState == FS_PENDING && !fetchAck && !fetchErr) |=> !sleepReq);

  a_r9_unpark: assert property (@(posedge clk) disable iff (!rstN)
    (fetchState == FS_PARKED && !sleepReq) |=> (fetchState == FS_REQUEST));
endmodule

bind wfi_sleep_ctrl sleep_chk #(.NIRQ(NIRQ)) uChk (
  .clk(clk), .rstN(rstN), .wfiExec(wfiExec), .privUser(privUser),
  .timeoutWait(timeoutWait), .dbgMode(dbgMode), .singleStep(singleStep),
  .irqPend(irqPend), .irqEn(irqEn), .dbgHaltReq(dbgHaltReq),
  .fetchAck(fetchAck), .fetchErr(fetchErr), .sleepReq(sleepReq),
  .illegalExc(illegalExc), .sleepOut(sleepOut), .fetchState(fetchState)
);

// File: tb/tb_wfi_sleep_ctrl.sv
module tb_wfi_sleep_ctrl;
  localparam int NIRQ = 4;
  logic clk = 1'b0;
  logic rstN, wfiExec, privUser, timeoutWait, dbgMode, singleStep, dbgHaltReq;
  logic bufFree, fetchAck, fetchErr;
  logic [NIRQ-1:0] irqPend, irqEn;
  logic fetchReq, sleepReq, cntInhibit, illegalExc, sleepOut;
  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  wfi_sleep_ctrl #(.NIRQ(NIRQ)) dut (
    .clk(clk), .rstN(rstN), .wfiExec(wfiExec), .privUser(privUser),
    .timeoutWait(timeoutWait), .dbgMode(dbgMode), .singleStep(singleStep),
    .irqPend(irqPend), .irqEn(irqEn), .dbgHaltReq(dbgHaltReq),
    .bufFree(bufFree), .fetchAck(fetchAck), .fetchErr(fetchErr),
    .fetchReq(fetchReq), .sleepReq(sleepReq), .cntInhibit(cntInhibit),
    .illegalExc(illegalExc), .sleepOut(sleepOut)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wakeByHalt();
    dbgHaltReq = 1'b1;
    tick();
    dbgHaltReq = 1'b0;
    tick();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected<=50000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rstN = 0; wfiExec = 0; privUser = 0; timeoutWait = 0; dbgMode = 0;
    singleStep = 0; dbgHaltReq = 0; bufFree = 1; fetchAck = 0; fetchErr = 0;
    irqPend = '0; irqEn = '0;
    repeat (3) tick();
    // R12: reset state
    chk("R12", "sleepReq", sleepReq, 1'b0);
    chk("R12", "cntInhibit", cntInhibit, 1'b0);
    chk("R12", "sleepOut", sleepOut, 1'b0);
    chk("R12", "illegalExc", illegalExc, 1'b0);
    chk("R12", "fetchReq in restart", fetchReq, 1'b0);
    bufFree = 0;
    rstN = 1;
    tick();
    bufFree = 1; #1;
    chk("R12", "fetchReq after restart", fetchReq, 1'b1);
    bufFree = 0;
    tick();

    // R1/R2/R3: sweep all mode combinations
    for (int m = 0; m < 16; m++) begin
      logic nop, ill, slp;
      nop = m[2] | m[3];
      ill = !nop && m[0] && m[1];
      slp = !nop && !ill;
      privUser = m[0]; timeoutWait = m[1]; dbgMode = m[2]; singleStep = m[3];
      wfiExec = 1;
      tick();
      wfiExec = 0;
      chk(ill ? "R2" : (nop ? "R3" : "R1"), "illegalExc", illegalExc, ill);
      chk(slp ? "R1" : (nop ? "R3" : "R2"), "sleepReq", sleepReq, slp);
      chk("R1", "cntInhibit", cntInhibit, slp);
      chk("R8", "sleepOut before park", sleepOut, 1'b0);
      tick();
      chk("R2", "illegalExc one cycle", illegalExc, 1'b0);
      chk("R8", "sleepOut parked", sleepOut, slp);
      privUser = 0; timeoutWait = 0; dbgMode = 0; singleStep = 0;
      if (slp) begin
        dbgHaltReq = 1;
        tick();
        dbgHaltReq = 0;
        chk("R5", "sleepReq after halt", sleepReq, 1'b0);
        chk("R10", "sleepOut falls with sleepReq", sleepOut, 1'b0);
        tick();
      end
    end

    // R4: sweep pending x enable
    for (int p = 0; p < 16; p++) begin
      for (int e = 0; e < 16; e++) begin
        logic hit;
        hit = ((p & e) != 0);
        wfiExec = 1;
        tick();
        wfiExec = 0;
        tick();
        chk("R8", "asleep before irq", sleepOut, 1'b1);
        irqPend = p[NIRQ-1:0]; irqEn = e[NIRQ-1:0];
        tick();
        chk("R4", "sleepReq vs irq", sleepReq, !hit);
        chk("R4", "cntInhibit vs irq", cntInhibit, !hit);
        irqPend = '0; irqEn = '0;
        wakeByHalt();
      end
    end

    // R6: wake condition already present
    irqPend = 4'b0100; irqEn = 4'b0110;
    wfiExec = 1;
    tick();
    wfiExec = 0;
    chk("R6", "no sleep with pending irq", sleepReq, 1'b0);
    irqPend = '0; irqEn = '0;
    tick();
    tick();
    chk("R6", "strobe not remembered", sleepReq, 1'b0);

    // R7/R11: fetch outstanding blocks entry
    bufFree = 1; #1;
    chk("R7", "fetchReq in request", fetchReq, 1'b1);
    tick();
    bufFree = 0; wfiExec = 1; #1;
    chk("R7", "fetchReq while pending", fetchReq, 1'b0);
    tick();
    wfiExec = 0;
    chk("R11", "entry blocked", sleepReq, 1'b0);
    tick();
    chk("R11", "still blocked", sleepReq, 1'b0);
    fetchAck = 1;
    tick();
    fetchAck = 0;
    chk("R11", "entry on ack", sleepReq, 1'b1);
    chk("R10", "sleepOut before park", sleepOut, 1'b0);
    tick();
    chk("R8", "sleepOut parked", sleepOut, 1'b1);

    // R9: unpark after wake
    irqPend = 4'b1000; irqEn = 4'b1000; bufFree = 1;
    tick();
    chk("R9", "awake", sleepReq, 1'b0);
    chk("R9", "fetchReq still parked", fetchReq, 1'b0);
    irqPend = '0; irqEn = '0;
    tick();
    chk("R9", "fetchReq resumes", fetchReq, 1'b1);
    bufFree = 0;
    tick();
    fetchErr = 1;
    tick();
    fetchErr = 0; bufFree = 1; #1;
    chk("R7", "err response returns to request", fetchReq, 1'b1);

    // R10: sleep while fetches continue
    wfiExec = 1;
    tick();
    wfiExec = 0; bufFree = 0;
    chk("R1", "asleep", sleepReq, 1'b1);
    chk("R10", "sleepOut with fetch open", sleepOut, 1'b0);
    tick();
    chk("R10", "sleepOut still open", sleepOut, 1'b0);
    fetchAck = 1;
    tick();
    fetchAck = 0;
    chk("R10", "sleepOut in request", sleepOut, 1'b0);
    tick();
    chk("R8", "sleepOut after park", sleepOut, 1'b1);
    dbgHaltReq = 1;
    tick();
    dbgHaltReq = 0;
    chk("R5", "halt wake", sleepReq, 1'b0);
    chk("R10", "sleepOut drops", sleepOut, 1'b0);
    tick();

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule